// File: doc/BRIEF.md
# Weighted Receive/Transmit DMA Arbiter

This block decides which of two DMA requesters, a receive channel and a transmit channel, owns a single host bus master. Each channel raises a request and receives a grant. A granted channel keeps the bus until it pulses its own done input. After that the arbiter spends one idle cycle and then makes a new decision.

A scheme bit selects how contention is resolved. In weighted mode, the receive channel may take a programmable number of consecutive grants, from one to four. After that, a waiting transmit channel wins the next decision. In fixed mode, receive wins every contention. A synchronous soft reset returns the arbiter to its idle, unweighted state on the next clock edge.

Top module: `rxtx_wdma_arb`

## Requirements
- R1: After the asynchronous reset rst_ni, both grants are low and the weight count is zero.
- R2: rx_gnt_o and tx_gnt_o are never high in the same cycle.
- R3: Once raised, a grant stays high until that channel's done input is sampled high. The other channel's done input, and changes on either request, have no effect on it.
- R4: In the cycle after a done is sampled on the granted channel, both grants are low. A new grant can appear one cycle later at the earliest.
- R5: When idle and exactly one channel requests, that channel is granted in the next cycle, whatever the weight count holds.
- R6: With scheme_i = 0 and both channels contending, receive wins until it has taken N consecutive grants, and then transmit wins. N is ratio_i + 1, so code 0 gives 1, code 1 gives 2, code 2 gives 3 and code 3 gives 4.
- R7: Every transmit grant clears the weight count. Receive then gets a fresh run of N grants.
- R8: With scheme_i = 1, receive wins every contention.
- R9: If soft_rst_i is sampled high, both grants are low and the weight count is zero in the next cycle. This takes precedence over every other input.
- R10: When idle with no request, no grant is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous clear of grant and weight count |
| scheme_i | input | 1 | 0 = weighted round-robin, 1 = fixed receive priority |
| ratio_i | input | RATIO_W | Receive grants per transmit grant, minus one |
| rx_req_i | input | 1 | Receive channel request |
| tx_req_i | input | 1 | Transmit channel request |
| rx_done_i | input | 1 | Receive channel releases its grant |
| tx_done_i | input | 1 | Transmit channel releases its grant |
| rx_gnt_o | output | 1 | Receive channel owns the bus |
| tx_gnt_o | output | 1 | Transmit channel owns the bus |

## Verification
Several properties are checked on every cycle:
- the grants never overlap;
- a grant is held until its own done;
- the bus goes idle after a done or a soft reset;
- a lone requester is served from idle;
- fixed mode always favours receive;
- an idle arbiter with no request stays idle.

The weighted sequence, where receive runs of exactly ratio_i + 1 grants are broken by one transmit grant, depends on history across many arbitrations. Only the bench can show it, by comparing the grant sequence against its cycle model for every ratio code. The bench also covers random traffic that mixes ratio changes with soft resets.

// File: rtl/rxtx_arb_pkg.sv
package rxtx_arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_RX   = 2'd1,
    OWN_TX   = 2'd2
  } owner_e;
endpackage

// File: rtl/rxtx_weight_ctr.sv
module rxtx_weight_ctr #(
  parameter int RATIO_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               rx_win_i,
  input  logic               tx_win_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               quota_met_o
);
  localparam int MAX_RUN = 2 ** RATIO_W;
  localparam int CNT_W   = $clog2(MAX_RUN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit       = CNT_W'(ratio_i) + CNT_W'(1);
  assign quota_met_o = (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i || tx_win_i) begin
      cnt_q <= '0;
    end else if (rx_win_i && (cnt_q != CNT_W'(MAX_RUN))) begin
      // saturate at the largest possible quota
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rxtx_pick.sv
module rxtx_pick (
  input  logic idle_i,
  input  logic rx_req_i,
  input  logic tx_req_i,
  input  logic scheme_i,
  input  logic quota_met_i,
  output logic rx_win_o,
  output logic tx_win_o
);
  logic contend;
  logic tx_turn;

  assign contend = rx_req_i && tx_req_i;
  // transmit wins a contention only in weighted mode once the quota is used
  assign tx_turn = !scheme_i && quota_met_i;

  always_comb begin
    rx_win_o = 1'b0;
    tx_win_o = 1'b0;
    if (idle_i) begin
      if (contend) begin
        rx_win_o = !tx_turn;
        tx_win_o = tx_turn;
      end else begin
        rx_win_o = rx_req_i;
        tx_win_o = tx_req_i;
      end
    end
  end
endmodule

// File: rtl/rxtx_grant_fsm.sv
module rxtx_grant_fsm
  import rxtx_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic rx_win_i,
  input  logic tx_win_i,
  input  logic rx_done_i,
  input  logic tx_done_i,
  output logic idle_o,
  output logic rx_gnt_o,
  output logic tx_gnt_o
);
  owner_e own_q, own_d;

  always_comb begin
    own_d = own_q;
    unique case (own_q)
      OWN_NONE: begin
        if (rx_win_i)      own_d = OWN_RX;
        else if (tx_win_i) own_d = OWN_TX;
      end
      OWN_RX:  if (rx_done_i) own_d = OWN_NONE;
      OWN_TX:  if (tx_done_i) own_d = OWN_NONE;
      default: own_d = OWN_NONE;
    endcase
    if (soft_rst_i) own_d = OWN_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) own_q <= OWN_NONE;
    else         own_q <= own_d;
  end

  assign idle_o   = (own_q == OWN_NONE);
  assign rx_gnt_o = (own_q == OWN_RX);
  assign tx_gnt_o = (own_q == OWN_TX);
endmodule

// File: rtl/rxtx_wdma_arb.sv
module rxtx_wdma_arb #(
  parameter int RATIO_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic               scheme_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               rx_req_i,
  input  logic               tx_req_i,
  input  logic               rx_done_i,
  input  logic               tx_done_i,
  output logic               rx_gnt_o,
  output logic               tx_gnt_o
);
  logic idle;
  logic quota_met;
  logic rx_win;
  logic tx_win;
  logic rx_take;
  logic tx_take;

  // a decision only counts when it is not cancelled by the soft reset
  assign rx_take = rx_win && !soft_rst_i;
  assign tx_take = tx_win && !soft_rst_i;

  rxtx_pick u_pick (
    .idle_i      (idle),
    .rx_req_i    (rx_req_i),
    .tx_req_i    (tx_req_i),
    .scheme_i    (scheme_i),
    .quota_met_i (quota_met),
    .rx_win_o    (rx_win),
    .tx_win_o    (tx_win)
  );

  rxtx_weight_ctr #(.RATIO_W(RATIO_W)) u_wctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (soft_rst_i),
    .rx_win_i    (rx_take),
    .tx_win_i    (tx_take),
    .ratio_i     (ratio_i),
    .quota_met_o (quota_met)
  );

  rxtx_grant_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .rx_win_i   (rx_win),
    .tx_win_i   (tx_win),
    .rx_done_i  (rx_done_i),
    .tx_done_i  (tx_done_i),
    .idle_o     (idle),
    .rx_gnt_o   (rx_gnt_o),
    .tx_gnt_o   (tx_gnt_o)
  );
endmodule

// File: rtl/rxtx_wdma_arb_chk.sv
module rxtx_wdma_arb_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic soft_rst_i,
  input logic scheme_i,
  input logic rx_req_i,
  input logic tx_req_i,
  input logic rx_done_i,
  input logic tx_done_i,
  input logic rx_gnt_o,
  input logic tx_gnt_o
);
  logic idle;
  assign idle = !rx_gnt_o && !tx_gnt_o;

  p_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_gnt_o && tx_gnt_o));

  p_rx_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_gnt_o && !rx_done_i && !soft_rst_i |=> rx_gnt_o);

  p_tx_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_gnt_o && !tx_done_i && !soft_rst_i |=> tx_gnt_o);

  p_rx_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_gnt_o && rx_done_i |=> idle);

  p_tx_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_gnt_o && tx_done_i |=> idle);

  p_lone_rx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && rx_req_i && !tx_req_i && !soft_rst_i |=> rx_gnt_o);

  p_lone_tx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && tx_req_i && !rx_req_i && !soft_rst_i |=> tx_gnt_o);

  p_fixed_rx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && rx_req_i && tx_req_i && scheme_i && !soft_rst_i |=> rx_gnt_o);

  p_soft_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> idle);

  p_no_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && !rx_req_i && !tx_req_i |=> idle);
endmodule

bind rxtx_wdma_arb rxtx_wdma_arb_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .soft_rst_i (soft_rst_i),
  .scheme_i   (scheme_i),
  .rx_req_i   (rx_req_i),
  .tx_req_i   (tx_req_i),
  .rx_done_i  (rx_done_i),
  .tx_done_i  (tx_done_i),
  .rx_gnt_o   (rx_gnt_o),
  .tx_gnt_o   (tx_gnt_o)
);

// File: tb/tb_rxtx_wdma_arb.sv
module tb_rxtx_wdma_arb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0, scheme = 1'b0;
  logic [1:0] ratio = 2'd0;
  logic       rx_req = 1'b0, tx_req = 1'b0, rx_done = 1'b0, tx_done = 1'b0;
  logic       rx_gnt, tx_gnt;

  int checks = 0;
  int errors = 0;
  int m_own = 0;  // 0 idle, 1 rx, 2 tx
  int m_cnt = 0;  // consecutive rx grants since last tx grant
  bit finished = 0;

  always #5 clk = ~clk;

  rxtx_wdma_arb #(.RATIO_W(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .scheme_i(scheme),
    .ratio_i(ratio), .rx_req_i(rx_req), .tx_req_i(tx_req),
    .rx_done_i(rx_done), .tx_done_i(tx_done),
    .rx_gnt_o(rx_gnt), .tx_gnt_o(tx_gnt)
  );

  function automatic int model_next_own(int own, int cnt, bit sr, bit rq, bit tq,
                                        bit rd, bit td, bit sch, int rat);
    if (sr) return 0;
    if (own == 1) return rd ? 0 : 1;
    if (own == 2) return td ? 0 : 2;
    if (rq && tq) return (sch || cnt < rat + 1) ? 1 : 2;
    if (rq) return 1;
    if (tq) return 2;
    return 0;
  endfunction

  task automatic check(string tag, bit got, bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    check({tag, " rx_gnt"}, rx_gnt, m_own == 1);
    check({tag, " tx_gnt"}, tx_gnt, m_own == 2);
  endtask

  // called at a negedge: drive, advance model, wait one cycle, compare
  task automatic step(bit rq, bit tq, bit rd, bit td, bit sr, string tag);
    int nxt;
    rx_req = rq; tx_req = tq; rx_done = rd; tx_done = td; soft_rst = sr;
    nxt = model_next_own(m_own, m_cnt, sr, rq, tq, rd, td, scheme, int'(ratio));
    if (sr) m_cnt = 0;
    else if (m_own == 0 && nxt == 1) m_cnt = (m_cnt < 4) ? m_cnt + 1 : 4;
    else if (m_own == 0 && nxt == 2) m_cnt = 0;
    m_own = nxt;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic weighted_run(int code);
    int run = 0;
    bit seen_tx = 0;
    bit prev_rx = 0, prev_tx = 0;
    ratio = 2'(code);
    scheme = 1'b0;
    step(0, 0, 0, 0, 1, "R9 clear before R6");
    for (int i = 0; i < 80; i++) begin
      step(1, 1, rx_gnt, tx_gnt, 0, "R6 model");
      if (tx_gnt && !prev_tx) begin
        if (seen_tx) begin
          checks++;
          if (run != code + 1) begin
            errors++;
            $display("FAIL R6/R7 ratio %0d: rx run %0d expected %0d", code, run, code + 1);
          end
        end
        seen_tx = 1; run = 0;
      end
      if (rx_gnt && !prev_rx) run++;
      prev_rx = rx_gnt; prev_tx = tx_gnt;
    end
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check("R1 rx_gnt in reset", rx_gnt, 0);
    check("R1 tx_gnt in reset", tx_gnt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    step(0, 0, 0, 0, 0, "R10 idle");
    step(0, 0, 0, 0, 0, "R10 idle");

    // lone requester, hold, other done ignored, release, idle gap
    step(0, 1, 0, 0, 0, "R5 lone tx");
    check("R5 tx granted", tx_gnt, 1);
    step(1, 1, 1, 0, 0, "R3 rx_done ignored by tx");
    check("R3 tx held", tx_gnt, 1);
    step(1, 0, 0, 1, 0, "R4 tx release");
    check("R4 idle after done", rx_gnt | tx_gnt, 0);
    step(1, 0, 0, 0, 0, "R4 regrant");
    check("R5 rx granted", rx_gnt, 1);
    step(0, 0, 0, 1, 0, "R3 tx_done ignored by rx");
    check("R3 rx held", rx_gnt, 1);
    step(0, 0, 0, 0, 1, "R9 soft reset");
    check("R9 grant cleared", rx_gnt | tx_gnt, 0);

    for (int c = 0; c < 4; c++) weighted_run(c);

    // fixed priority: transmit never wins a contention
    scheme = 1'b1; ratio = 2'd0;
    step(0, 0, 0, 0, 1, "R9 clear before R8");
    for (int i = 0; i < 30; i++) begin
      step(1, 1, rx_gnt, 0, 0, "R8 model");
      check("R8 no tx grant", tx_gnt, 0);
    end

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit rq, tq, rd, td, sr;
      if (i % 200 == 0) begin
        scheme = ($urandom_range(3) == 0);
        ratio = 2'($urandom_range(3));
      end
      rq = ($urandom_range(3) != 0);
      tq = ($urandom_range(3) != 0);
      rd = ($urandom_range(2) == 0);
      td = ($urandom_range(2) == 0);
      sr = ($urandom_range(63) == 0);
      step(rq, tq, rd, td, sr, "R2 R3 R5 R6 R7 random");
      check("R2 exclusive", rx_gnt & tx_gnt, 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule